// File: doc/BRIEF.md
# Byte-Banked Local Data Memory Tile

This block is the private 4 KB data store of one processor core. The storage is split into four banks, each one byte wide and 1024 entries deep. Every bank has its own 10-bit address bus, its own chip-enable and its own write-enable. A full-word access and a single-byte access can therefore both be issued on any clock. A word access drives the same row address to all four banks. A byte access wakes only the bank that holds the addressed byte, and the other three stay idle.

The core issues one request per cycle. A request carries a byte address, an access size, a read/write flag, a signed-load flag and a 32-bit store value. The tile answers exactly one cycle later with a response strobe, a 32-bit load result and an error flag.

A byte load returns its lane in the low byte of the result. The upper 24 bits are filled with copies of bit 7 of that byte when the signed flag is set, and with zeros when it is not. A byte store takes its value from bits [7:0] of the store bus. A word access whose address is not a multiple of four is rejected: no bank is enabled, and the response carries the error flag.

Flow control is one-sided. The tile has no ready output and never stalls a request. Every request that the core marks valid is accepted in the cycle it is presented. The response cannot be held off either, so the core must take it in the cycle it appears.

The bank address, chip-enable and write-enable lines are brought out as ports so that the per-bank activity can be observed.

Top module: `byte_bank_tile`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with no request pending, `rsp_valid` and `rsp_err` are 0.
- R2: A valid word request (`req_size`=1) with `req_addr[1:0]`=0 raises all four bits of `bank_ce` in the same cycle. Each 10-bit field `bank_addr[10*i+9:10*i]` then carries `req_addr[11:2]`.
- R3: A valid byte request (`req_size`=0) raises exactly bit `req_addr[1:0]` of `bank_ce`. That bank's address field carries `req_addr[11:2]`. The other bits of `bank_ce` and `bank_we` are 0.
- R4: A byte store writes `req_wdata[7:0]` to the addressed byte only. Bits [31:8] of `req_wdata` and the other three bytes of the same word are left untouched.
- R5: Word lanes are little-endian. The byte at address 4k+i holds bits [8i+7:8i] of the word stored at address 4k, and a word load returns it in the same position.
- R6: `rsp_valid` is 1 in the cycle after each cycle in which `req_valid` is 1, and 0 otherwise. Back-to-back requests are served every cycle.
- R7: A byte load returns the addressed byte in `rsp_rdata[7:0]`. The upper 24 bits equal bit 7 of that byte when `req_signed`=1, and are 0 when `req_signed`=0.
- R8: A valid word request with `req_addr[1:0]`≠0 asserts no `bank_ce` and no `bank_we`. Its response has `rsp_err`=1 and `rsp_rdata`=0, and the memory contents are unchanged.
- R9: The response to an accepted store has `rsp_err`=0 and `rsp_rdata`=0.
- R10: `bank_we` is 1 only where `bank_ce` is 1, and only for stores. With `req_valid`=0, all of `bank_ce` and `bank_we` are 0 and no location changes, whatever the other request inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; the banks and response registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the response registers |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 12 | Byte address of the access |
| req_size | input | 1 | 0 = byte access, 1 = word access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Byte loads: 1 = sign-extend, 0 = zero-extend |
| req_wdata | input | 32 | Store value (a byte store uses bits [7:0]) |
| bank_addr | output | 40 | Four 10-bit bank row addresses; bank i uses bits [10i+9:10i] |
| bank_ce | output | 4 | Per-bank chip-enable |
| bank_we | output | 4 | Per-bank write-enable |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Load result, or zero for stores and rejected accesses |
| rsp_err | output | 1 | The answered request was a misaligned word access |

## Verification
The properties assume that `req_size`, `req_write`, `req_signed` and `req_addr` hold known values whenever `req_valid` is high. They also assume that a load never targets a byte that has not been written since power-up, because such a byte has no defined content. The stimulus keeps to both. It first fills every word of the tile with a computed pattern before any load is issued. It drives all request fields to defined values on every cycle, including idle cycles, where they carry deliberately misleading store data.

// File: rtl/tile_pkg.sv
package tile_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/tile_decode.sv
module tile_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LANES  = 4,
  localparam int unsigned SEL_W   = $clog2(LANES),
  localparam int unsigned BANK_AW = ADDR_W - SEL_W,
  localparam int unsigned DATA_W  = LANES * tile_pkg::LANE_W
) (
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_size,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic [LANES-1:0]         ce,
  output logic [LANES-1:0]         we,
  output logic [LANES*BANK_AW-1:0] addr,
  output logic [DATA_W-1:0]        wdata,
  output logic                     misalign,
  output logic                     is_word,
  output logic [SEL_W-1:0]         lane
);
  import tile_pkg::*;

  logic [BANK_AW-1:0] row;

  always_comb begin
    lane     = req_addr[SEL_W-1:0];
    row      = req_addr[ADDR_W-1:SEL_W];
    is_word  = (acc_size_e'(req_size) == SZ_WORD);
    misalign = req_valid && is_word && (lane != '0);
    for (int i = 0; i < LANES; i++) begin
      ce[i] = req_valid && !misalign && (is_word || (lane == SEL_W'(i)));
      we[i] = ce[i] && req_write;
      addr[i*BANK_AW +: BANK_AW] = ce[i] ? row : '0;
      wdata[i*LANE_W +: LANE_W]  = is_word ? req_wdata[i*LANE_W +: LANE_W]
                                           : req_wdata[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/byte_bank.sv
module byte_bank #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/tile_merge.sv
module tile_merge #(
  parameter int unsigned LANES = 4,
  localparam int unsigned SEL_W  = $clog2(LANES),
  localparam int unsigned DATA_W = LANES * tile_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              misalign,
  input  logic              is_word,
  input  logic              req_write,
  input  logic              req_signed,
  input  logic [SEL_W-1:0]  lane,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  import tile_pkg::*;

  logic             q_word, q_write, q_signed;
  logic [SEL_W-1:0] q_lane;
  logic [LANE_W-1:0] pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      q_word    <= 1'b0;
      q_write   <= 1'b0;
      q_signed  <= 1'b0;
      q_lane    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= misalign;
      q_word    <= is_word;
      q_write   <= req_write;
      q_signed  <= req_signed;
      q_lane    <= lane;
    end
  end

  always_comb begin
    pick = bank_rdata[q_lane*LANE_W +: LANE_W];
    if (!rsp_valid || rsp_err || q_write)
      rsp_rdata = '0;
    else if (q_word)
      rsp_rdata = bank_rdata;
    else
      rsp_rdata = {{(DATA_W-LANE_W){q_signed & pick[LANE_W-1]}}, pick};
  end
endmodule

// File: rtl/byte_bank_tile.sv
module byte_bank_tile #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES   = DATA_W / tile_pkg::LANE_W,
  localparam int unsigned SEL_W   = $clog2(LANES),
  localparam int unsigned BANK_AW = ADDR_W - SEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_size,
  input  logic                     req_write,
  input  logic                     req_signed,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic [LANES*BANK_AW-1:0] bank_addr,
  output logic [LANES-1:0]         bank_ce,
  output logic [LANES-1:0]         bank_we,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_err
);
  import tile_pkg::*;

  logic [DATA_W-1:0] bank_wdata;
  logic [DATA_W-1:0] bank_rdata;
  logic              misalign;
  logic              is_word;
  logic [SEL_W-1:0]  lane;

  tile_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .ce        (bank_ce),
    .we        (bank_we),
    .addr      (bank_addr),
    .wdata     (bank_wdata),
    .misalign  (misalign),
    .is_word   (is_word),
    .lane      (lane)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    byte_bank #(.AW(BANK_AW), .DW(LANE_W)) u_bank (
      .clk   (clk),
      .ce    (bank_ce[g]),
      .we    (bank_we[g]),
      .addr  (bank_addr[g*BANK_AW +: BANK_AW]),
      .wdata (bank_wdata[g*LANE_W +: LANE_W]),
      .rdata (bank_rdata[g*LANE_W +: LANE_W])
    );
  end

  tile_merge #(.LANES(LANES)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .misalign   (misalign),
    .is_word    (is_word),
    .req_write  (req_write),
    .req_signed (req_signed),
    .lane       (lane),
    .bank_rdata (bank_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/tile_checker.sv
module tile_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_size,
  input logic              req_write,
  input logic              req_signed,
  input logic [LANES-1:0]  bank_ce,
  input logic [LANES-1:0]  bank_we,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err
);
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size && (req_addr[1:0] == 2'b00) |-> (bank_ce == '1)); // R2

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_size |-> ($countones(bank_ce) == 1) && bank_ce[req_addr[1:0]]); // R3

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R6

  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R6

  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && !$past(req_size) && !$past(req_write) && !$past(req_signed)
      |-> (rsp_rdata[DATA_W-1:8] == '0)); // R7

  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && !$past(req_size) && !$past(req_write) && $past(req_signed)
      |-> (rsp_rdata[DATA_W-1:8] == {(DATA_W-8){rsp_rdata[7]}})); // R7

  AST_MISALIGN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size && (req_addr[1:0] != 2'b00) |-> (bank_ce == '0) && (bank_we == '0)); // R8

  AST_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size && (req_addr[1:0] != 2'b00) |=> rsp_err && (rsp_rdata == '0)); // R8

  AST_STORE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(req_write) |-> (rsp_rdata == '0)); // R9

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we & ~bank_ce) == '0); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (bank_ce == '0) && (bank_we == '0)); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !rsp_valid && !rsp_err); // R1
endmodule

bind byte_bank_tile tile_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_byte_bank_tile.sv
`timescale 1ns/1ps
module tb_byte_bank_tile;
  localparam int AW = 12;
  localparam int NBYTES = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic        req_size = 1'b0;
  logic        req_write = 1'b0;
  logic        req_signed = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [39:0] bank_addr;
  logic [3:0]  bank_ce;
  logic [3:0]  bank_we;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  byte_bank_tile dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_signed(req_signed),
    .req_wdata(req_wdata), .bank_addr(bank_addr), .bank_ce(bank_ce),
    .bank_we(bank_we), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  always #4 clk = ~clk;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit done = 1'b0;

  logic [7:0] refm [NBYTES];

  bit          e_pend = 1'b0;
  bit          e_err  = 1'b0;
  logic [31:0] e_data = '0;
  string       e_tag  = "R6";

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    logic [31:0] v;
    v = 32'(k) * 32'h9E37_79B1;
    return v ^ {v[15:0], v[31:16]} ^ 32'(k);
  endfunction

  task automatic check_rsp();
    chk(rsp_valid === e_pend, "R6 rsp_valid", 40'(rsp_valid), 40'(e_pend));
    if (e_pend) begin
      chk(rsp_err === e_err, {e_tag, " rsp_err"}, 40'(rsp_err), 40'(e_err));
      chk(rsp_rdata === e_data, {e_tag, " rsp_rdata"}, 40'(rsp_rdata), 40'(e_data));
    end
  endtask

  task automatic issue(input bit v, input logic [11:0] a, input bit sz, input bit wr,
                       input bit sg, input logic [31:0] wd, input string tag);
    logic [3:0] xce, xwe;
    bit mis;
    int ln;
    @(negedge clk);
    check_rsp();
    req_valid = v; req_addr = a; req_size = sz; req_write = wr;
    req_signed = sg; req_wdata = wd;
    #1;
    ln  = int'(a[1:0]);
    mis = v && sz && (a[1:0] != 2'b00);
    if (!v || mis)  xce = 4'h0;
    else if (sz)    xce = 4'hF;
    else            xce = 4'(1 << ln);
    xwe = wr ? xce : 4'h0;
    chk(bank_ce === xce, !v ? "R10 bank_ce" : mis ? "R8 bank_ce" : sz ? "R2 bank_ce" : "R3 bank_ce",
        40'(bank_ce), 40'(xce));
    chk(bank_we === xwe, !v ? "R10 bank_we" : "R3 bank_we", 40'(bank_we), 40'(xwe));
    for (int i = 0; i < 4; i++)
      if (xce[i])
        chk(bank_addr[i*10 +: 10] === a[11:2], sz ? "R2 bank_addr" : "R3 bank_addr",
            40'(bank_addr[i*10 +: 10]), 40'(a[11:2]));
    e_pend = v; e_err = mis; e_tag = tag;
    if (!v || mis || wr) e_data = '0;
    else if (sz) e_data = {refm[a+3], refm[a+2], refm[a+1], refm[a]};
    else e_data = {{24{sg & refm[a][7]}}, refm[a]};
    if (v && !mis && wr) begin
      if (sz) for (int i = 0; i < 4; i++) refm[a + 12'(i)] = wd[i*8 +: 8];
      else refm[a] = wd[7:0];
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && rsp_err === 1'b0, "R1 in reset", {rsp_valid, rsp_err}, 40'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && rsp_err === 1'b0, "R1 after reset", {rsp_valid, rsp_err}, 40'h0);

    // R5/R9: fill every word, little-endian lanes
    for (int k = 0; k < NBYTES / 4; k++) issue(1, 12'(4 * k), 1, 1, 0, pat(k), "R9");
    for (int k = 0; k < NBYTES / 4; k++) issue(1, 12'(4 * k), 1, 0, 0, 32'hFFFF_FFFF, "R5");
    // R7: every byte, signed and unsigned
    for (int a = 0; a < NBYTES; a++)
      for (int s = 0; s < 2; s++) issue(1, 12'(a), 0, 0, s[0], 32'h0, "R7");
    // R10: idle cycles carrying store-looking inputs
    for (int k = 0; k < 16; k++) issue(0, 12'(k * 64), k[0], 1, 0, 32'hDEAD_BEEF, "R10");
    // R4: byte stores with junk upper bits, then verify whole words
    for (int a = 0; a < NBYTES; a += 5)
      issue(1, 12'(a), 0, 1, 0, {24'hC3C3C3, 8'(a * 13 + 7)}, "R9");
    for (int k = 0; k < NBYTES / 4; k++) issue(1, 12'(4 * k), 1, 0, 0, 32'h0, "R4");
    // R8: misaligned word loads and stores are refused
    for (int k = 0; k < 64; k++)
      for (int off = 1; off < 4; off++) begin
        issue(1, 12'(4 * k * 16 + off), 1, 1, 0, 32'h5A5A_A5A5, "R8");
        issue(1, 12'(4 * k * 16 + off), 1, 0, 1, 32'h0, "R8");
      end
    for (int k = 0; k < 64; k++) issue(1, 12'(4 * k * 16), 1, 0, 0, 32'h0, "R8");
    issue(0, 12'h0, 0, 0, 0, 32'h0, "R6");
    issue(0, 12'h0, 0, 0, 0, 32'h0, "R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule